// File: doc/BRIEF.md
# Configurable Threshold Logic Gate

This block is one threshold element. It has N binary inputs, a signed integer weight for each input and a signed integer threshold. The output is 1 when the sum of the weights of the asserted inputs is at least the threshold. All settings load through a small write-only configuration port that is registered on the clock. The gate output itself is combinational in the data inputs.

A polarity mask makes any input act in complemented form. An output-invert bit gives the complementary function. The block does not rewrite the stored values. It derives the equivalent effective weight vector and effective threshold in hardware and drives them as status outputs. Software can then read the linear form that is actually being evaluated. A complemented input negates its weight and lowers the threshold by that weight. Output inversion uses a strict comparison on the negated sum and threshold, so the complement stays exact even when the weighted sum lands on the threshold.

The configuration address map puts the weights at offsets 0 to N-1, the threshold at offset N and a mode word at offset N+1. The weights use ascending input index, and the bench and the status outputs rely on that order.

Top module: `threshold_gate`

## Requirements
- R1: After reset all weights, the threshold, the polarity mask and the invert bit are zero. Every effective weight and the effective threshold read zero, and the output is 1 for every input pattern (0 >= 0).
- R2: A write with `cfg_we` high to address i (0 <= i < N) stores `cfg_data` as the signed weight of input i. The new weight takes effect from the next rising clock edge.
- R3: A write to address N stores `cfg_data` as the signed threshold.
- R4: A write to address N+1 stores the mode word. Bits [N-1:0] form the polarity mask (bit i set means input i is used complemented) and bit W-1 is the output-invert bit. All other bits of the mode word are ignored.
- R5: A cycle with `cfg_we` low, or a write to an address at or above N+2, changes no stored setting. The output and status show no change.
- R6: With invert clear, `gate_out` is 1 exactly when the sum of w_i·(x_i XOR p_i) over all inputs is greater than or equal to T. The sum and the comparison are signed, and the output follows `in_x` with no clock.
- R7: Effective weight i, a (W+1)-bit signed field at bits [i*(W+1) +: W+1] of `eff_w_flat`, equals -w_i when mask bit i is set and w_i otherwise. A stored weight of -2^(W-1) therefore shows as +2^(W-1).
- R8: `eff_thr` equals T minus the sum of the stored weights of all complemented inputs, as a signed value of the width given in the port table.
- R9: With invert set, `gate_out` is the exact complement of the R6 result for every input pattern. This includes patterns whose weighted sum equals the threshold.
- R10: The sum and the effective threshold never wrap. This holds even when all weights and the threshold sit at their most negative or most positive values and every input is complemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N+2) | Configuration address: weights, threshold, mode |
| cfg_data | input | W | Configuration write data |
| in_x | input | N | Binary data inputs |
| gate_out | output | 1 | Threshold element result |
| eff_w_flat | output | N*(W+1) | Effective signed weights, input 0 in the low field |
| eff_thr | output | W+1+$clog2(N+1) | Effective signed threshold |

## Verification
The bench builds the block with N=4 and W=8. Every one of the 16 input patterns can then be swept after each configuration, so each weight/threshold/mask/invert setting is checked over its whole truth table and not just sampled. An 8-bit weight reaches -128, where negation needs the extra effective-weight bit. Four such weights together with an extreme threshold drive the effective threshold close to the edge of its range. Directed cases cover the NOR and six-five-four-two examples and a sum that lands exactly on the threshold under inversion. Random weights, thresholds and masks fill in the rest.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

   // Signed width that holds any weighted sum or shifted threshold without wrap.
   function automatic int sum_width(input int n_in, input int w_bits);
      return w_bits + 1 + $clog2(n_in + 1);
   endfunction

   typedef enum logic [1:0] {
      SEL_WEIGHT = 2'd0,
      SEL_THRESH = 2'd1,
      SEL_MODE   = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

endpackage

// File: rtl/tlg_cfg_regs.sv
module tlg_cfg_regs
   import tlg_pkg::*;
#(
   parameter int N  = 4,
   parameter int W  = 8,
   parameter int AW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [AW-1:0]  cfg_addr,
   input  logic [W-1:0]   cfg_data,
   output logic [N*W-1:0] wt_q,
   output logic [W-1:0]   thr_q,
   output logic [N-1:0]   pol_q,
   output logic           inv_q
);

   localparam int INV_BIT = W - 1;

   logic [W-1:0] wt_r [N];
   cfg_sel_e     sel;

   always_comb begin
      sel = SEL_NONE;
      if (cfg_we) begin
         if (cfg_addr < AW'(N))         sel = SEL_WEIGHT;
         else if (cfg_addr == AW'(N))   sel = SEL_THRESH;
         else if (cfg_addr == AW'(N+1)) sel = SEL_MODE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) wt_r[i] <= '0;
         thr_q <= '0;
         pol_q <= '0;
         inv_q <= 1'b0;
      end else begin
         unique case (sel)
            SEL_WEIGHT: begin
               for (int i = 0; i < N; i++)
                  if (cfg_addr == AW'(i)) wt_r[i] <= cfg_data;
            end
            SEL_THRESH: thr_q <= cfg_data;
            SEL_MODE: begin
               pol_q <= cfg_data[N-1:0];
               inv_q <= cfg_data[INV_BIT];
            end
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_wt_out
      assign wt_q[i*W +: W] = wt_r[i];

      AST_WEIGHT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == AW'(i)) |=> (wt_q[i*W +: W] == $past(cfg_data))); // R2
   end

   AST_THRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(N)) |=> (thr_q == $past(cfg_data))); // R3

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(N+1)) |=>
         (pol_q == $past(cfg_data[N-1:0]) && inv_q == $past(cfg_data[INV_BIT]))); // R4

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr <= AW'(N+1)) |=>
         ($stable(wt_q) && $stable(thr_q) && $stable(pol_q) && $stable(inv_q))); // R5

endmodule

// File: rtl/tlg_polarity.sv
module tlg_polarity #(
   parameter int N  = 4,
   parameter int W  = 8,
   parameter int SW = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N*W-1:0]        wt_flat,
   input  logic [W-1:0]          thr,
   input  logic [N-1:0]          pol,
   output logic [N*(W+1)-1:0]    eff_w_flat,
   output logic signed [SW-1:0]  eff_thr
);

   localparam int EW = W + 1;

   for (genvar i = 0; i < N; i++) begin : g_eff_w
      logic signed [EW-1:0] ext;
      logic signed [SW-1:0] wide;
      assign ext  = EW'($signed(wt_flat[i*W +: W]));
      assign wide = SW'($signed(wt_flat[i*W +: W]));
      assign eff_w_flat[i*EW +: EW] = pol[i] ? -ext : ext;

      AST_POL_THR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
         ($stable(wt_flat) && $stable(thr) && $rose(pol[i]) &&
          ((pol ^ $past(pol)) == (N'(1) << i)))
         |-> (eff_thr == $past(eff_thr) - wide)); // R8
   end

   always_comb begin
      eff_thr = SW'($signed(thr));
      for (int i = 0; i < N; i++)
         if (pol[i]) eff_thr = eff_thr - SW'($signed(wt_flat[i*W +: W]));
   end

   AST_NOPOL_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pol == '0) |-> (eff_thr == SW'($signed(thr)))); // R8

endmodule

// File: rtl/tlg_sum_cmp.sv
module tlg_sum_cmp #(
   parameter int N  = 4,
   parameter int W  = 8,
   parameter int SW = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          in_x,
   input  logic [N*(W+1)-1:0]    eff_w_flat,
   input  logic signed [SW-1:0]  eff_thr,
   input  logic                  inv,
   output logic                  gate_out
);

   localparam int EW = W + 1;

   logic signed [SW-1:0] wsum;
   logic signed [SW-1:0] neg_sum;
   logic signed [SW-1:0] neg_thr;
   logic                 hit_true;
   logic                 hit_compl;

   always_comb begin
      wsum = '0;
      for (int i = 0; i < N; i++)
         if (in_x[i]) wsum = wsum + SW'($signed(eff_w_flat[i*EW +: EW]));
   end

   // Complement formed as a strict compare of the negated values: exact at equality.
   assign neg_sum   = -wsum;
   assign neg_thr   = -eff_thr;
   assign hit_true  = (wsum >= eff_thr);
   assign hit_compl = (neg_sum > neg_thr);
   assign gate_out  = inv ? hit_compl : hit_true;

   AST_INV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(in_x) && $stable(eff_w_flat) && $stable(eff_thr) && (inv != $past(inv)))
      |-> (gate_out != $past(gate_out))); // R9

   AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_x == '0) |-> (gate_out == (inv ^ (eff_thr <= 0)))); // R6

endmodule

// File: rtl/threshold_gate.sv
module threshold_gate
   import tlg_pkg::*;
#(
   parameter int N = 4,
   parameter int W = 8,
   localparam int AW = $clog2(N + 2),
   localparam int SW = tlg_pkg::sum_width(N, W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [AW-1:0]         cfg_addr,
   input  logic [W-1:0]          cfg_data,
   input  logic [N-1:0]          in_x,
   output logic                  gate_out,
   output logic [N*(W+1)-1:0]    eff_w_flat,
   output logic signed [SW-1:0]  eff_thr
);

   if (N < 1) begin : g_bad_n
      $error("threshold_gate: N must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("threshold_gate: W must be at least 2");
   end
   if (N > W - 1) begin : g_bad_mode
      $error("threshold_gate: mode word needs N polarity bits below the invert bit");
   end

   logic [N*W-1:0] wt_q;
   logic [W-1:0]   thr_q;
   logic [N-1:0]   pol_q;
   logic           inv_q;

   tlg_cfg_regs #(.N(N), .W(W), .AW(AW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_data (cfg_data),
      .wt_q     (wt_q),
      .thr_q    (thr_q),
      .pol_q    (pol_q),
      .inv_q    (inv_q)
   );

   tlg_polarity #(.N(N), .W(W), .SW(SW)) u_pol (
      .clk        (clk),
      .rst_n      (rst_n),
      .wt_flat    (wt_q),
      .thr        (thr_q),
      .pol        (pol_q),
      .eff_w_flat (eff_w_flat),
      .eff_thr    (eff_thr)
   );

   tlg_sum_cmp #(.N(N), .W(W), .SW(SW)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_x       (in_x),
      .eff_w_flat (eff_w_flat),
      .eff_thr    (eff_thr),
      .inv        (inv_q),
      .gate_out   (gate_out)
   );

endmodule

// File: tb/threshold_gate_bench.sv
module threshold_gate_bench;

   localparam int N  = 4;
   localparam int W  = 8;
   localparam int AW = $clog2(N + 2);
   localparam int SW = W + 1 + $clog2(N + 1);
   localparam int EW = W + 1;
   localparam int CLK_PERIOD = 10;
   localparam int NPAT = 1 << N;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_we = 1'b0;
   logic [AW-1:0]        cfg_addr = '0;
   logic [W-1:0]         cfg_data = '0;
   logic [N-1:0]         in_x = '0;
   logic                 gate_out;
   logic [N*EW-1:0]      eff_w_flat;
   logic signed [SW-1:0] eff_thr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   // reference model of the stored configuration
   int wm [N];
   int tm = 0;
   int pm = 0;
   int im = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   threshold_gate #(.N(N), .W(W)) u_threshold_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_data   (cfg_data),
      .in_x       (in_x),
      .gate_out   (gate_out),
      .eff_w_flat (eff_w_flat),
      .eff_thr    (eff_thr)
   );

   function automatic int sx(input int v);
      int r;
      r = v & ((1 << W) - 1);
      if (r >= (1 << (W-1))) r = r - (1 << W);
      return r;
   endfunction

   function automatic int ref_out(input int x);
      int s;
      int b;
      s = 0;
      for (int i = 0; i < N; i++) begin
         b = ((x >> i) & 1) ^ ((pm >> i) & 1);
         s = s + wm[i] * b;
      end
      return (im != 0) ? ((s >= tm) ? 0 : 1) : ((s >= tm) ? 1 : 0);
   endfunction

   function automatic int ref_eff_w(input int i);
      return (((pm >> i) & 1) != 0) ? -wm[i] : wm[i];
   endfunction

   function automatic int ref_eff_thr();
      int t;
      t = tm;
      for (int i = 0; i < N; i++)
         if (((pm >> i) & 1) != 0) t = t - wm[i];
      return t;
   endfunction

   function automatic int dut_eff_w(input int i);
      logic signed [EW-1:0] f;
      f = eff_w_flat[i*EW +: EW];
      return int'(f);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_addr = a[AW-1:0];
      cfg_data = d[W-1:0];
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   task automatic set_weight(input int i, input int v);
      wm[i] = sx(v);
      wr(i, v);
   endtask

   task automatic set_thr(input int v);
      tm = sx(v);
      wr(N, v);
   endtask

   task automatic set_mode(input int mask, input int inv);
      pm = mask & ((1 << N) - 1);
      im = inv;
      wr(N + 1, pm | (inv << (W - 1)));
   endtask

   task automatic check_status(input string req);
      for (int i = 0; i < N; i++) chk(req, dut_eff_w(i), ref_eff_w(i));
      chk(req, int'(eff_thr), ref_eff_thr());
   endtask

   task automatic sweep(input string req);
      for (int x = 0; x < NPAT; x++) begin
         @(negedge clk);
         in_x = x[N-1:0];
         #1;
         chk(req, int'(gate_out), ref_out(x));
      end
   endtask

   task automatic probe(input string req, input int x, input int exp);
      @(negedge clk);
      in_x = x[N-1:0];
      #1;
      chk(req, int'(gate_out), exp);
   endtask

   initial begin
      int seed_val;
      int y1, y2, y3, y4, e;
      seed_val = $urandom(32'h5EED_0042);
      for (int i = 0; i < N; i++) wm[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_status("R1");
      probe("R1", 0, 1);
      probe("R1", NPAT - 1, 1);

      // R2 R3 R6: NOR from weights -1,-1, threshold 0
      set_weight(0, -1); set_weight(1, -1); set_weight(2, 0); set_weight(3, 0);
      set_thr(0);
      for (int x = 0; x < NPAT; x++) probe("R6", x, ((x & 3) == 0) ? 1 : 0);
      check_status("R2");

      // R6: weights 6,5,4,2 threshold 8 realise y1y2+y1y3+y1y4+y2y3
      set_weight(0, 6); set_weight(1, 5); set_weight(2, 4); set_weight(3, 2);
      set_thr(8);
      chk("R3", int'(eff_thr), 8);
      for (int x = 0; x < NPAT; x++) begin
         y1 = x & 1; y2 = (x >> 1) & 1; y3 = (x >> 2) & 1; y4 = (x >> 3) & 1;
         e = (y1 & y2) | (y1 & y3) | (y1 & y4) | (y2 & y3);
         probe("R6", x, e);
      end

      // R7 R8: complemented inputs 0 and 2
      set_mode(4'b0101, 0);
      chk("R8", int'(eff_thr), -2);
      chk("R7", dut_eff_w(0), -6);
      chk("R7", dut_eff_w(2), -4);
      check_status("R8");
      sweep("R6");

      // R4: mode bits other than mask and invert are ignored
      wr(N + 1, 32'h70);
      pm = 0; im = 0;
      check_status("R4");
      sweep("R4");

      // R9: sum exactly on the threshold, inverted
      for (int i = 0; i < N; i++) set_weight(i, 1);
      set_thr(2);
      set_mode(0, 0);
      probe("R9", 3, 1);
      set_mode(0, 1);
      probe("R9", 3, 0);
      probe("R9", 1, 1);
      sweep("R9");

      // R10: extremes
      for (int i = 0; i < N; i++) set_weight(i, -128);
      set_thr(127);
      set_mode((1 << N) - 1, 0);
      chk("R10", dut_eff_w(0), 128);
      chk("R10", int'(eff_thr), 127 + 128 * N);
      check_status("R10");
      sweep("R10");
      for (int i = 0; i < N; i++) set_weight(i, 127);
      set_thr(-128);
      set_mode(0, 1);
      chk("R10", int'(eff_thr), -128);
      sweep("R10");

      // R5: writes to unmapped addresses and data without strobe
      wr(N + 2, 32'h55);
      wr((1 << AW) - 1, 32'hAA);
      @(negedge clk);
      cfg_addr = '0; cfg_data = 8'h33;
      @(negedge clk);
      cfg_addr = AW'(N); cfg_data = 8'h44;
      @(negedge clk);
      check_status("R5");
      sweep("R5");

      // random configurations
      for (int it = 0; it < 200; it++) begin
         for (int i = 0; i < N; i++) set_weight(i, int'($urandom() & 32'hFF));
         set_thr(int'($urandom() & 32'hFF));
         set_mode(int'($urandom() & ((1 << N) - 1)), int'($urandom() & 1));
         check_status("R7");
         sweep((im != 0) ? "R9" : "R6");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule